// File: doc/BRIEF.md
# Configurable Serial Character Framer

This block turns bytes into asynchronous serial characters on a transmit line and turns characters seen on a receive line back into bytes. The character format is chosen at run time: five to eight data bits, one or two stop bits, and a parity bit that is odd, even, forced high, forced low or absent. The transmit and receive sides each have their own eight-entry queue and their own state machine. They can run one at a time, take turns on a shared line, or run together.

An external divider supplies a single-cycle enable, `baud_tick`, at sixteen times the bit rate. The transmitter moves one bit every sixteen ticks. The receiver samples the line on every tick, votes over three samples at the centre of each bit and ignores start pulses that are too short. Each received byte leaves through a valid/ready stream together with its own parity and framing error flags. A separate overrun flag reports a character that was lost because the receive queue was full. Each side copies the format inputs at the start of a character, so changing them during a character has no effect until the next one begins.

Top module: `uart_framer`

## Requirements
- R1: After reset `txd` is high, `tx_ready` is high, and `tx_busy`, `rx_valid` and `rx_overrun` are low.
- R2: A transmitted character is one low start bit, then the data bits least significant first, then the parity bit when one is enabled, then one stop bit (`cfg_two_stop`=0) or two stop bits (`cfg_two_stop`=1) at the high level. Each bit lasts 16 `baud_tick` periods. The number of data bits is `cfg_len`+5, so codes 0..3 give 5..8 bits.
- R3: `cfg_parity` codes are 0 none, 1 odd (data bits plus parity bit hold an odd number of ones), 2 even, 3 mark (parity bit always 1) and 4 space (parity bit always 0). Codes 5..7 behave as none.
- R4: The receiver delivers each character's data bits on `rx_data[7:0]`, least significant bit first, and fills the unused upper bits with zero when the length is below 8.
- R5: `rx_parity_err` is high alongside a character whose received parity bit differs from the bit required by its parity mode.
- R6: `rx_frame_err` is high alongside a character in which a low level was sampled at any stop position. That character is still delivered.
- R7: A low pulse on `rxd` shorter than half a bit produces no character.
- R8: The transmit queue holds 8 bytes and `tx_ready` is low while it is full. Queued bytes are sent back to back in the order written. `tx_busy` is high while a character is on the line or waiting in the queue.
- R9: The receive queue holds 8 characters. A character that completes while the queue is full is dropped and `rx_overrun` goes high. `rx_overrun` stays high until the next character is read.
- R10: Each side samples the format inputs when a character begins. A change in the middle of a character does not alter that character.
- R11: Transmit and receive run at the same time. With `txd` looped back to `rxd`, every byte sent is received unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_len | input | 2 | Data length code, bits = code + 5 |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_parity | input | 3 | Parity mode code |
| baud_tick | input | 1 | Enable pulse at 16 times the bit rate |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmit queue can accept a byte |
| txd | output | 1 | Serial transmit line |
| tx_busy | output | 1 | Character on the line or waiting to be sent |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_data | output | 8 | Received byte |
| rx_parity_err | output | 1 | Parity error flag for `rx_data` |
| rx_frame_err | output | 1 | Framing error flag for `rx_data` |
| rx_valid | output | 1 | A received character is available |
| rx_ready | input | 1 | Consumer takes the character |
| rx_overrun | output | 1 | A character was lost to a full receive queue |

## Verification
Two events can land in the same clock cycle, and both are provoked on purpose. The host can write the transmit queue in the cycle the transmit engine pulls its head entry. A completed character can arrive at a full receive queue, or at a queue that is being read. A burst of nine bytes is written faster than the line drains, so writes overlap engine pulls while the queue fills to its limit. The looped-back receiver is kept unread until the ninth character overflows. Results are judged at the ports: `tx_ready` must drop at eight entries, the eight characters read back must match the first eight written in order, the ninth must be absent, and `rx_overrun` must hold until the first read.

// File: rtl/uart_fr_pkg.sv
package uart_fr_pkg;

   localparam int DATA_W = 8;

   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_START = 3'd1,
      S_DATA  = 3'd2,
      S_PAR   = 3'd3,
      S_STOP  = 3'd4
   } ser_state_e;

   typedef struct packed {
      logic [1:0] len;
      logic       two_stop;
      logic [2:0] par;
   } frame_cfg_t;

   function automatic logic [DATA_W-1:0] len_mask(input logic [1:0] len);
      return 8'hFF >> (2'd3 - len);
   endfunction

   function automatic logic has_par(input logic [2:0] p);
      return (p >= 3'd1) && (p <= 3'd4);
   endfunction

   function automatic logic par_val(input logic [2:0] p,
                                    input logic [DATA_W-1:0] d,
                                    input logic [1:0] len);
      logic x;
      x = ^(d & len_mask(len));
      case (p)
         3'd1:    return ~x;
         3'd2:    return x;
         3'd3:    return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/uart_fr_fifo.sv
module uart_fr_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             full,
   output logic             empty
);
   localparam int  PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CW   = $clog2(DEPTH + 1);
   localparam bit  POW2 = (DEPTH & (DEPTH - 1)) == 0;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("uart_fr_fifo: DEPTH must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("uart_fr_fifo: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wp, rp, wp_nx, rp_nx;
   logic [CW-1:0]    cnt;
   logic             do_push, do_pop;

   generate
      if (POW2) begin : g_wrap_pow2
         assign wp_nx = wp + PW'(1);
         assign rp_nx = rp + PW'(1);
      end else begin : g_wrap_cmp
         assign wp_nx = (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
         assign rp_nx = (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      end
   endgenerate

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   // R8 / R9: writers must respect full, readers must respect empty
   a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));

endmodule

// File: rtl/uart_fr_tx.sv
module uart_fr_tx
   import uart_fr_pkg::*;
#(
   parameter int OSR = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  frame_cfg_t        cfg,
   input  logic              q_empty,
   input  logic [DATA_W-1:0] q_data,
   output logic              q_pop,
   output logic              txd,
   output logic              active
);
   localparam int CNT_W = $clog2(OSR);

   ser_state_e        st;
   logic [CNT_W-1:0]  cnt;
   logic [2:0]        bitn;
   logic              stop2nd;
   logic [DATA_W-1:0] sh;
   frame_cfg_t        cfg_q;
   logic              pbit;
   logic              bit_end, last_stop, launch;
   logic [2:0]        last_idx;

   assign bit_end   = tick && (cnt == CNT_W'(OSR - 1));
   assign last_stop = (st == S_STOP) && bit_end && (!cfg_q.two_stop || stop2nd);
   assign launch    = tick && !q_empty && ((st == S_IDLE) || last_stop);
   assign q_pop     = launch;
   assign last_idx  = 3'(cfg_q.len) + 3'd4;
   assign active    = (st != S_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         cnt     <= '0;
         bitn    <= '0;
         stop2nd <= 1'b0;
         sh      <= '0;
         cfg_q   <= '0;
         pbit    <= 1'b0;
      end else if (launch) begin
         st      <= S_START;
         cnt     <= '0;
         bitn    <= '0;
         stop2nd <= 1'b0;
         sh      <= q_data;
         cfg_q   <= cfg;
         pbit    <= par_val(cfg.par, q_data, cfg.len);
      end else if (tick && (st != S_IDLE)) begin
         if (!bit_end) begin
            cnt <= cnt + CNT_W'(1);
         end else begin
            cnt <= '0;
            case (st)
               S_START: st <= S_DATA;
               S_DATA: begin
                  sh   <= sh >> 1;
                  bitn <= bitn + 3'd1;
                  if (bitn == last_idx)
                     st <= has_par(cfg_q.par) ? S_PAR : S_STOP;
               end
               S_PAR:  st <= S_STOP;
               S_STOP: begin
                  if (cfg_q.two_stop && !stop2nd) stop2nd <= 1'b1;
                  else                            st      <= S_IDLE;
               end
               default: st <= S_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      case (st)
         S_START: txd = 1'b0;
         S_DATA:  txd = sh[0];
         S_PAR:   txd = pbit;
         default: txd = 1'b1;
      endcase
   end

   // R2: a byte drawn from the queue is followed at once by the start level
   a_r2_start_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
      q_pop |=> !txd);
   // R10: captured format holds for the whole character
   a_r10_tx_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((st != S_IDLE) && !launch) |=> $stable(cfg_q));

endmodule

// File: rtl/uart_fr_rx.sv
module uart_fr_rx
   import uart_fr_pkg::*;
#(
   parameter int OSR      = 16,
   parameter int SYNC     = 2,
   parameter bit MAJORITY = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                rxd,
   input  frame_cfg_t          cfg,
   input  logic                q_full,
   input  logic                q_pop,
   output logic                q_push,
   output logic [DATA_W+1:0]   q_din,
   output logic                overrun
);
   localparam int CNT_W = $clog2(OSR);
   localparam int HALF  = OSR / 2;

   generate
      if (OSR < 8 || (OSR % 2) != 0) begin : g_bad_osr
         $error("uart_fr_rx: OSR must be even and at least 8");
      end
      if (SYNC < 2) begin : g_bad_sync
         $error("uart_fr_rx: SYNC must be at least 2");
      end
   endgenerate

   logic [SYNC-1:0]   sy;
   logic              rx_s;
   logic [1:0]        samp;
   logic              vote;
   ser_state_e        st;
   logic [CNT_W-1:0]  cnt;
   logic [2:0]        bitn;
   logic              stop2nd, ferr, rpar;
   logic [DATA_W-1:0] sh;
   frame_cfg_t        cfg_q;
   logic              bit_end, done, ferr_fin, perr_fin;
   logic [DATA_W-1:0] data_fin;
   logic [2:0]        last_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sy <= '1;
      else        sy <= {sy[SYNC-2:0], rxd};
   end
   assign rx_s = sy[SYNC-1];

   generate
      if (MAJORITY) begin : g_vote3
         assign vote = (samp[1] & samp[0]) | (samp[1] & rx_s) | (samp[0] & rx_s);
      end else begin : g_vote1
         assign vote = rx_s;
      end
   endgenerate

   assign bit_end  = (cnt == CNT_W'(OSR - 1));
   assign last_idx = 3'(cfg_q.len) + 3'd4;
   assign done     = tick && (st == S_STOP) && bit_end && (!cfg_q.two_stop || stop2nd);
   assign data_fin = sh >> (2'd3 - cfg_q.len);
   assign ferr_fin = ferr | !vote;
   assign perr_fin = has_par(cfg_q.par) && (rpar != par_val(cfg_q.par, data_fin, cfg_q.len));
   assign q_push   = done && !q_full;
   assign q_din    = {ferr_fin, perr_fin, data_fin};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         samp    <= '1;
         st      <= S_IDLE;
         cnt     <= '0;
         bitn    <= '0;
         stop2nd <= 1'b0;
         ferr    <= 1'b0;
         rpar    <= 1'b0;
         sh      <= '0;
         cfg_q   <= '0;
      end else if (tick) begin
         samp <= {samp[0], rx_s};
         case (st)
            S_IDLE: begin
               if (!rx_s) begin
                  st  <= S_START;
                  cnt <= '0;
               end
            end
            S_START: begin
               if (cnt == CNT_W'(HALF - 2)) begin
                  cnt <= '0;
                  if (!vote) begin
                     st      <= S_DATA;
                     cfg_q   <= cfg;
                     bitn    <= '0;
                     ferr    <= 1'b0;
                     stop2nd <= 1'b0;
                  end else begin
                     st <= S_IDLE;
                  end
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            default: begin
               if (!bit_end) begin
                  cnt <= cnt + CNT_W'(1);
               end else begin
                  cnt <= '0;
                  case (st)
                     S_DATA: begin
                        sh   <= {vote, sh[DATA_W-1:1]};
                        bitn <= bitn + 3'd1;
                        if (bitn == last_idx)
                           st <= has_par(cfg_q.par) ? S_PAR : S_STOP;
                     end
                     S_PAR: begin
                        rpar <= vote;
                        st   <= S_STOP;
                     end
                     default: begin
                        if (!vote) ferr <= 1'b1;
                        if (cfg_q.two_stop && !stop2nd) stop2nd <= 1'b1;
                        else                            st      <= S_IDLE;
                     end
                  endcase
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              overrun <= 1'b0;
      else if (done && q_full) overrun <= 1'b1;
      else if (q_pop)          overrun <= 1'b0;
   end

   // R9: the overrun flag only rises when a character met a full queue
   a_r9_overrun_on_full: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(q_full));
   // R10: captured format holds while bits are being collected
   a_r10_rx_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((st != S_IDLE) && (st != S_START)) |=> $stable(cfg_q));

endmodule

// File: rtl/uart_framer.sv
module uart_framer
   import uart_fr_pkg::*;
#(
   parameter int FIFO_DEPTH  = 8,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit MAJORITY    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] cfg_len,
   input  logic       cfg_two_stop,
   input  logic [2:0] cfg_parity,
   input  logic       baud_tick,
   input  logic [7:0] tx_data,
   input  logic       tx_valid,
   output logic       tx_ready,
   output logic       txd,
   output logic       tx_busy,
   input  logic       rxd,
   output logic [7:0] rx_data,
   output logic       rx_parity_err,
   output logic       rx_frame_err,
   output logic       rx_valid,
   input  logic       rx_ready,
   output logic       rx_overrun
);
   localparam int RXW = DATA_W + 2;

   frame_cfg_t        cfg;
   logic              txq_full, txq_empty, txq_pop, tx_active;
   logic [DATA_W-1:0] txq_dout;
   logic              rxq_full, rxq_empty, rxq_push, rxq_pop;
   logic [RXW-1:0]    rxq_din, rxq_dout;

   assign cfg = '{len: cfg_len, two_stop: cfg_two_stop, par: cfg_parity};

   assign tx_ready = !txq_full;
   assign tx_busy  = tx_active || !txq_empty;

   uart_fr_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .push(tx_valid && !txq_full), .din(tx_data),
      .pop(txq_pop), .dout(txq_dout),
      .full(txq_full), .empty(txq_empty)
   );

   uart_fr_tx #(.OSR(OSR)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .cfg(cfg),
      .q_empty(txq_empty), .q_data(txq_dout), .q_pop(txq_pop),
      .txd(txd), .active(tx_active)
   );

   uart_fr_rx #(.OSR(OSR), .SYNC(SYNC_STAGES), .MAJORITY(MAJORITY)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd(rxd), .cfg(cfg),
      .q_full(rxq_full), .q_pop(rxq_pop), .q_push(rxq_push),
      .q_din(rxq_din), .overrun(rx_overrun)
   );

   uart_fr_fifo #(.WIDTH(RXW), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push(rxq_push), .din(rxq_din),
      .pop(rxq_pop), .dout(rxq_dout),
      .full(rxq_full), .empty(rxq_empty)
   );

   assign rx_valid      = !rxq_empty;
   assign rxq_pop       = rx_valid && rx_ready;
   assign rx_data       = rxq_dout[DATA_W-1:0];
   assign rx_parity_err = rxq_dout[DATA_W];
   assign rx_frame_err  = rxq_dout[DATA_W+1];

   // R1: an idle transmitter with nothing queued keeps the line high
   a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> txd);

endmodule

// File: tb/uart_framer_test.sv
module uart_framer_test;
   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 4;
   localparam int OSR        = 16;
   localparam int BIT_CLKS   = TICK_DIV * OSR;
   localparam int NVEC       = 9;
   // {len code, two stop, parity code, data}
   localparam logic [13:0] VECS [NVEC] = '{
      {2'd3, 1'b0, 3'd0, 8'hA5},
      {2'd3, 1'b1, 3'd2, 8'h3C},
      {2'd0, 1'b0, 3'd1, 8'h1F},
      {2'd1, 1'b1, 3'd3, 8'hFF},
      {2'd2, 1'b0, 3'd4, 8'h55},
      {2'd2, 1'b1, 3'd1, 8'h80},
      {2'd0, 1'b1, 3'd2, 8'h0A},
      {2'd3, 1'b0, 3'd1, 8'h00},
      {2'd1, 1'b0, 3'd5, 8'h2D}
   };

   logic       clk = 1'b0, rst_n = 1'b0;
   logic [1:0] cfg_len = 2'd3;
   logic       cfg_two_stop = 1'b0;
   logic [2:0] cfg_parity = 3'd0;
   logic       baud_tick = 1'b0;
   logic [7:0] tx_data = '0;
   logic       tx_valid = 1'b0, rx_ready = 1'b0;
   logic       tx_ready, txd, tx_busy, rxd;
   logic [7:0] rx_data;
   logic       rx_parity_err, rx_frame_err, rx_valid, rx_overrun;
   logic       loop_en = 1'b1, rxd_drv = 1'b1;
   int         tdiv = 0;
   int         checks = 0, errs = 0;

   assign rxd = loop_en ? txd : rxd_drv;

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) begin
      tdiv      <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
      baud_tick <= (tdiv == TICK_DIV - 1);
   end

   uart_framer uut (
      .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_two_stop(cfg_two_stop),
      .cfg_parity(cfg_parity), .baud_tick(baud_tick), .tx_data(tx_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd), .tx_busy(tx_busy),
      .rxd(rxd), .rx_data(rx_data), .rx_parity_err(rx_parity_err),
      .rx_frame_err(rx_frame_err), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .rx_overrun(rx_overrun)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int frame_bits(input logic [1:0] len, input logic two,
                                     input logic [2:0] par, input logic [7:0] d,
                                     output logic [11:0] bits);
      int n;
      int nb;
      logic [7:0] m;
      logic ones;
      nb = int'(len) + 5;
      m = 8'((1 << nb) - 1);
      ones = ^(d & m);
      bits = '1;
      bits[0] = 1'b0;
      n = 1;
      for (int i = 0; i < nb; i++) begin
         bits[n] = d[i];
         n++;
      end
      if (par >= 3'd1 && par <= 3'd4) begin
         case (par)
            3'd1: bits[n] = ~ones;
            3'd2: bits[n] = ones;
            3'd3: bits[n] = 1'b1;
            default: bits[n] = 1'b0;
         endcase
         n++;
      end
      n += two ? 2 : 1;
      return n;
   endfunction

   task automatic tx_push(input logic [7:0] d);
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
      tx_data  = d;
      tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   task automatic watch_tx(input logic [1:0] len, input logic two, input logic [2:0] par,
                           input logic [7:0] d, input string req);
      logic [11:0] bits, got;
      int n, waited, mism;
      n = frame_bits(len, two, par, d, bits);
      got = '1;
      waited = 0;
      mism = 0;
      @(negedge clk);
      while (txd !== 1'b0 && waited < 4000) begin
         @(negedge clk);
         waited++;
      end
      repeat (BIT_CLKS / 2) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         got[i] = txd;
         if (txd !== bits[i]) mism++;
         if (i < n - 1) repeat (BIT_CLKS) @(negedge clk);
      end
      chk(mism == 0, req, 32'(got), 32'(bits));
   endtask

   task automatic rx_pop(output logic [7:0] d, output logic pe, output logic fe, output bit got);
      int w;
      w = 0;
      got = 1'b0;
      d = '0; pe = 1'b0; fe = 1'b0;
      @(negedge clk);
      while (!rx_valid && w < 2000) begin
         @(negedge clk);
         w++;
      end
      if (rx_valid) begin
         got = 1'b1;
         d = rx_data; pe = rx_parity_err; fe = rx_frame_err;
         rx_ready = 1'b1;
         @(negedge clk);
         rx_ready = 1'b0;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin : main
      logic [11:0] bits;
      logic [7:0]  d;
      logic        pe, fe;
      bit          got;
      int          n, mism;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(txd === 1'b1, "R1 txd", 32'(txd), 1);
      chk(tx_ready === 1'b1, "R1 tx_ready", 32'(tx_ready), 1);
      chk(tx_busy === 1'b0, "R1 tx_busy", 32'(tx_busy), 0);
      chk(rx_valid === 1'b0, "R1 rx_valid", 32'(rx_valid), 0);
      chk(rx_overrun === 1'b0, "R1 rx_overrun", 32'(rx_overrun), 0);

      // R2 R3 R4 R11: table of formats in loopback
      loop_en = 1'b1;
      for (int v = 0; v < NVEC; v++) begin
         logic [1:0] l;
         logic       t;
         logic [2:0] p;
         logic [7:0] x;
         logic [7:0] m;
         {l, t, p, x} = VECS[v];
         cfg_len = l; cfg_two_stop = t; cfg_parity = p;
         m = 8'((1 << (int'(l) + 5)) - 1);
         fork
            tx_push(x);
            watch_tx(l, t, p, x, "R2/R3 line frame");
         join
         rx_pop(d, pe, fe, got);
         chk(got && d === (x & m), "R4/R11 loopback data", 32'(d), 32'(x & m));
         chk(got && !pe && !fe, "R5/R6 no error flags", 32'({pe, fe}), 0);
      end

      // R5: wrong parity bit on an 8-bit even-parity character
      loop_en = 1'b0;
      cfg_len = 2'd3; cfg_two_stop = 1'b0; cfg_parity = 3'd2;
      n = frame_bits(2'd3, 1'b0, 3'd2, 8'h01, bits);
      bits[9] = ~bits[9];
      for (int i = 0; i < n; i++) begin
         rxd_drv = bits[i];
         repeat (BIT_CLKS) @(negedge clk);
      end
      rxd_drv = 1'b1;
      rx_pop(d, pe, fe, got);
      chk(got && pe === 1'b1, "R5 parity error flag", 32'(pe), 1);
      chk(got && d === 8'h01, "R5 data with parity error", 32'(d), 32'h01);
      chk(got && fe === 1'b0, "R6 no framing error on good stop", 32'(fe), 0);

      // R6: second stop bit low
      cfg_parity = 3'd0; cfg_two_stop = 1'b1;
      n = frame_bits(2'd3, 1'b1, 3'd0, 8'h42, bits);
      for (int i = 0; i < n - 1; i++) begin
         rxd_drv = bits[i];
         repeat (BIT_CLKS) @(negedge clk);
      end
      rxd_drv = 1'b0;
      repeat (BIT_CLKS / 2 + 12) @(negedge clk);
      rxd_drv = 1'b1;
      rx_pop(d, pe, fe, got);
      chk(got && fe === 1'b1, "R6 framing error flag", 32'(fe), 1);
      chk(got && d === 8'h42, "R6 character still delivered", 32'(d), 32'h42);
      repeat (2 * BIT_CLKS) @(negedge clk);

      // R7: short start pulse
      rxd_drv = 1'b0;
      repeat (20) @(negedge clk);
      rxd_drv = 1'b1;
      repeat (5 * BIT_CLKS) @(negedge clk);
      chk(rx_valid === 1'b0, "R7 glitch rejected", 32'(rx_valid), 0);

      // R10: format change in the middle of a character
      loop_en = 1'b1;
      cfg_len = 2'd3; cfg_two_stop = 1'b0; cfg_parity = 3'd0;
      fork
         tx_push(8'hA5);
         watch_tx(2'd3, 1'b0, 3'd0, 8'hA5, "R10 frame kept format");
         begin
            wait (txd === 1'b0);
            repeat (3 * BIT_CLKS) @(negedge clk);
            chk(tx_busy === 1'b1, "R8 busy during frame", 32'(tx_busy), 1);
            cfg_len = 2'd0; cfg_two_stop = 1'b1; cfg_parity = 3'd2;
         end
      join
      rx_pop(d, pe, fe, got);
      chk(got && d === 8'hA5 && !pe && !fe, "R10 receiver kept format",
          32'({fe, pe, d}), 32'h0A5);
      cfg_len = 2'd3; cfg_two_stop = 1'b0; cfg_parity = 3'd0;
      repeat (2 * BIT_CLKS) @(negedge clk);

      // R8 R9: burst of nine, receiver not read
      for (int i = 0; i < 9; i++) tx_push(8'h10 + 8'(i));
      @(negedge clk);
      chk(tx_ready === 1'b0, "R8 queue full at eight", 32'(tx_ready), 0);
      repeat (10 * 10 * BIT_CLKS) @(negedge clk);
      chk(rx_overrun === 1'b1, "R9 overrun raised", 32'(rx_overrun), 1);
      chk(tx_busy === 1'b0, "R8 busy clears when drained", 32'(tx_busy), 0);
      mism = 0;
      for (int i = 0; i < 8; i++) begin
         rx_pop(d, pe, fe, got);
         if (!got || d !== 8'h10 + 8'(i)) mism++;
         if (i == 0) chk(rx_overrun === 1'b0, "R9 overrun cleared by read", 32'(rx_overrun), 0);
      end
      chk(mism == 0, "R8/R9 order of first eight", 32'(mism), 0);
      repeat (4) @(negedge clk);
      chk(rx_valid === 1'b0, "R9 ninth character dropped", 32'(rx_valid), 0);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule